// File: doc/BRIEF.md
# Keyed indexed configuration-space controller

This block holds the configuration registers of a multi-function peripheral-controller chip and presents them on a simple 8-bit I/O bus. The bus has an address, a read strobe, a write strobe, write data and read data. After reset the register file is locked. A host unlocks it by writing a key byte to a fixed configuration port. It then reaches every register through an index/data pair of ports. Writing the exit key to the same port locks the file again.

Most registers are banked. An index-addressed device-number register chooses which logical device's bank the data port reaches. Each ordinary device has these fields:
- an activate bit,
- a primary and a secondary 16-bit base address, each stored high byte first,
- a primary and a secondary interrupt select.

One extra bank, the auxiliary bank, holds GPIO control bytes. Every stored field is driven straight onto the block's outputs, so the peripheral functions beside it can be wired to their own settings. Those peripheral functions are not part of this block.

Top module: `cfgspace_ctrl`

## Requirements
- R1: After reset the block is in the run state. `cfg_mode_o` is 0, every output field is 0 (all devices inactive), the device-number register is 0 and the index register is 0.
- R2: Writing 0x55 to the index port (default address 0x3F0) in the run state enters the configuration state (`cfg_mode_o`=1). In the configuration state, writing 0xAA to that port returns to the run state. Neither key write changes the index register.
- R3: In the run state, nothing reaches the register file:
  - writes to the data port (index port + 1) and writes of any value other than 0x55 to the index port change no register;
  - reads of either port return 0xFF.
- R4: In the configuration state, a write of any value other than 0xAA to the index port loads the index register. A read of the index port returns the index register. Reads of any undecoded address, or reads with `rd_en` low, return 0xFF.
- R5: Index 0x07 is the device-number register. It holds 8 bits and is readable and writable. Its value selects the bank that the banked indexes reach.
- R6: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to either are discarded.
- R7: For device numbers 0 to 7, index 0x30 bit 0 is that device's activate bit, driven on `dev_active_o[n]`. It reads back with bits 7:1 as 0.
- R8: In a device bank, indexes 0x60 and 0x61 hold the high and low bytes of the primary base, on `pri_base_o[16n+15:16n]`. Indexes 0x62 and 0x63 hold the high and low bytes of the secondary base, on `sec_base_o`.
- R9: In a device bank, index 0x70 is the primary interrupt select (`pri_irq_o[8n+7:8n]`) and index 0x72 is the secondary interrupt select (`sec_irq_o`). Each is 8 bits and kept per device.
- R10: With device number 8 selected, indexes 0xC0+k (k=0..7) are GPIO control bytes. The fields are:
  - bit0 is direction (`gpio_dir_o[k]`, 1=input);
  - bit1 is polarity invert (`gpio_inv_o[k]`);
  - bit2 is the combined-interrupt enable (`gpio_irqen_o[k]`);
  - bits 4:3 are the function select (`gpio_fsel_o[2k+1:2k]`, 00=original, 01=alternate 1).

  Bits 7:5 read back as 0.
- R11: Any index not listed above reads 0x00 and discards writes. This also applies to a device-bank index when bank 8 or a number above 8 is selected, and to a GPIO index in a device bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | I/O address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address and state |
| cfg_mode_o | output | 1 | 1 while in the configuration state |
| dev_active_o | output | 8 | Activate bit per device 0..7 |
| pri_base_o | output | 128 | Primary base address per device, 16 bits each |
| sec_base_o | output | 128 | Secondary base address per device, 16 bits each |
| pri_irq_o | output | 64 | Primary interrupt select per device, 8 bits each |
| sec_irq_o | output | 64 | Secondary interrupt select per device, 8 bits each |
| gpio_dir_o | output | 8 | GPIO direction bit per control byte |
| gpio_inv_o | output | 8 | GPIO polarity invert bit per control byte |
| gpio_irqen_o | output | 8 | GPIO combined-interrupt enable per control byte |
| gpio_fsel_o | output | 16 | GPIO function select, 2 bits per control byte |

## Verification
The bench builds the block with its default parameters: eight ordinary banks, an auxiliary bank of eight GPIO bytes and an 8-bit index. At that size every one of the 256 indexes can be swept under four device numbers:
- an ordinary bank;
- the auxiliary bank;
- the first number past it;
- 0xFF.

Each sweep is compared against a bench model built from the requirements, with only the exit-key index skipped, since writing it to the index port locks the file. Discard sweeps write 0xFF to every unimplemented index, then check that no output moved. Run-state writes are aimed at an armed index to show that nothing leaks through while locked.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam logic [7:0] KEY_ENTER = 8'h55;
    localparam logic [7:0] KEY_LEAVE = 8'hAA;

    localparam logic [7:0] IX_DEVNUM = 8'h07;
    localparam logic [7:0] IX_ID     = 8'h20;
    localparam logic [7:0] IX_REV    = 8'h21;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] IX_PB_HI  = 8'h60;
    localparam logic [7:0] IX_PB_LO  = 8'h61;
    localparam logic [7:0] IX_SB_HI  = 8'h62;
    localparam logic [7:0] IX_SB_LO  = 8'h63;
    localparam logic [7:0] IX_PIRQ   = 8'h70;
    localparam logic [7:0] IX_SIRQ   = 8'h72;

    localparam logic [7:0] CHIP_ID  = 8'h30;
    localparam logic [7:0] CHIP_REV = 8'h01;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } cfg_state_e;

    typedef enum logic [2:0] {
        F_NONE,
        F_ACT,
        F_PB_HI,
        F_PB_LO,
        F_SB_HI,
        F_SB_LO,
        F_PIRQ,
        F_SIRQ
    } dev_field_e;

    typedef struct packed {
        logic        act;
        logic [15:0] pbase;
        logic [15:0] sbase;
        logic [7:0]  pirq;
        logic [7:0]  sirq;
    } dev_bank_t;

    typedef struct packed {
        logic [1:0] fsel;
        logic       irqen;
        logic       inv;
        logic       dir;
    } gpio_ctl_t;

    function automatic dev_field_e dev_field(input logic [7:0] idx);
        case (idx)
            IX_ACT:   return F_ACT;
            IX_PB_HI: return F_PB_HI;
            IX_PB_LO: return F_PB_LO;
            IX_SB_HI: return F_SB_HI;
            IX_SB_LO: return F_SB_LO;
            IX_PIRQ:  return F_PIRQ;
            IX_SIRQ:  return F_SIRQ;
            default:  return F_NONE;
        endcase
    endfunction

    function automatic logic [7:0] dev_read(input dev_bank_t b, input dev_field_e f);
        case (f)
            F_ACT:   return {7'd0, b.act};
            F_PB_HI: return b.pbase[15:8];
            F_PB_LO: return b.pbase[7:0];
            F_SB_HI: return b.sbase[15:8];
            F_SB_LO: return b.sbase[7:0];
            F_PIRQ:  return b.pirq;
            F_SIRQ:  return b.sirq;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_port_fsm.sv
module cfg_port_fsm
    import cfgspace_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [15:0] IDX_PORT = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic              cfg_mode,
    output logic [7:0]        idx_q,
    output logic              data_wr,
    output logic              data_rd,
    output logic              idx_rd
);
    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_PORT);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(IDX_PORT + 16'd1);

    cfg_state_e state_q;
    logic       at_idx;
    logic       at_data;

    assign at_idx  = (addr == IDX_A);
    assign at_data = (addr == DATA_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            idx_q   <= 8'h00;
        end else if (wr_en && at_idx) begin
            case (state_q)
                ST_RUN: begin
                    if (wdata == KEY_ENTER) state_q <= ST_CFG;
                end
                default: begin
                    if (wdata == KEY_LEAVE) state_q <= ST_RUN;
                    else                    idx_q   <= wdata;
                end
            endcase
        end
    end

    assign cfg_mode = (state_q == ST_CFG);
    assign data_wr  = cfg_mode && wr_en && at_data;
    assign data_rd  = cfg_mode && rd_en && at_data;
    assign idx_rd   = cfg_mode && rd_en && at_idx;

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfgspace_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       wr,
    input  dev_field_e field,
    input  logic [7:0] wdata,
    output dev_bank_t  bank_q,
    output logic [7:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (sel && wr) begin
            case (field)
                F_ACT:   bank_q.act         <= wdata[0];
                F_PB_HI: bank_q.pbase[15:8] <= wdata;
                F_PB_LO: bank_q.pbase[7:0]  <= wdata;
                F_SB_HI: bank_q.sbase[15:8] <= wdata;
                F_SB_LO: bank_q.sbase[7:0]  <= wdata;
                F_PIRQ:  bank_q.pirq        <= wdata;
                F_SIRQ:  bank_q.sirq        <= wdata;
                default: ;
            endcase
        end
    end

    assign rd_data = sel ? dev_read(bank_q, field) : 8'h00;

endmodule

// File: rtl/cfg_gpio_bank.sv
module cfg_gpio_bank
    import cfgspace_pkg::*;
#(
    parameter int unsigned GPIO_NUM  = 8,
    parameter logic [7:0]  GPIO_BASE = 8'hC0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic            wr,
    input  logic [7:0]      idx,
    input  logic [4:0]      wdata,
    output gpio_ctl_t       ctl_q [GPIO_NUM],
    output logic [7:0]      rd_data
);
    logic [GPIO_NUM-1:0] hit;

    for (genvar k = 0; k < GPIO_NUM; k++) begin : g_byte
        assign hit[k] = (idx == 8'(GPIO_BASE + 8'(k)));

        always_ff @(posedge clk) begin
            if (rst)
                ctl_q[k] <= '0;
            else if (sel && wr && hit[k])
                ctl_q[k] <= gpio_ctl_t'(wdata);
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < GPIO_NUM; k++) begin
            if (sel && hit[k]) rd_data = {3'b000, ctl_q[k]};
        end
    end

endmodule

// File: rtl/cfgspace_ctrl.sv
module cfgspace_ctrl
    import cfgspace_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] IDX_PORT  = 16'h03F0,
    parameter int unsigned NUM_DEV   = 8,
    parameter logic [7:0]  AUX_LDN   = 8'd8,
    parameter int unsigned GPIO_NUM  = 8,
    parameter logic [7:0]  GPIO_BASE = 8'hC0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  cfg_mode_o,
    output logic [NUM_DEV-1:0]    dev_active_o,
    output logic [NUM_DEV*16-1:0] pri_base_o,
    output logic [NUM_DEV*16-1:0] sec_base_o,
    output logic [NUM_DEV*8-1:0]  pri_irq_o,
    output logic [NUM_DEV*8-1:0]  sec_irq_o,
    output logic [GPIO_NUM-1:0]   gpio_dir_o,
    output logic [GPIO_NUM-1:0]   gpio_inv_o,
    output logic [GPIO_NUM-1:0]   gpio_irqen_o,
    output logic [GPIO_NUM*2-1:0] gpio_fsel_o
);
    logic       cfg_mode;
    logic [7:0] idx_q;
    logic       data_wr;
    logic       data_rd;
    logic       idx_rd;
    logic [7:0] ldn_q;

    cfg_port_fsm #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (IDX_PORT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .cfg_mode (cfg_mode),
        .idx_q    (idx_q),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .idx_rd   (idx_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ldn_q <= 8'h00;
        else if (data_wr && idx_q == IX_DEVNUM)
            ldn_q <= wdata;
    end

    dev_field_e field;
    assign field = dev_field(idx_q);

    dev_bank_t  bank [NUM_DEV];
    logic [7:0] dev_rd [NUM_DEV];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        cfg_dev_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .sel     (ldn_q == 8'(i)),
            .wr      (data_wr),
            .field   (field),
            .wdata   (wdata),
            .bank_q  (bank[i]),
            .rd_data (dev_rd[i])
        );
        assign dev_active_o[i]        = bank[i].act;
        assign pri_base_o[i*16 +: 16] = bank[i].pbase;
        assign sec_base_o[i*16 +: 16] = bank[i].sbase;
        assign pri_irq_o[i*8 +: 8]    = bank[i].pirq;
        assign sec_irq_o[i*8 +: 8]    = bank[i].sirq;
    end

    gpio_ctl_t  gctl [GPIO_NUM];
    logic [7:0] gpio_rd;

    cfg_gpio_bank #(
        .GPIO_NUM  (GPIO_NUM),
        .GPIO_BASE (GPIO_BASE)
    ) u_gpio (
        .clk     (clk),
        .rst     (rst),
        .sel     (ldn_q == AUX_LDN),
        .wr      (data_wr),
        .idx     (idx_q),
        .wdata   (wdata[4:0]),
        .ctl_q   (gctl),
        .rd_data (gpio_rd)
    );

    for (genvar k = 0; k < GPIO_NUM; k++) begin : g_gout
        assign gpio_dir_o[k]        = gctl[k].dir;
        assign gpio_inv_o[k]        = gctl[k].inv;
        assign gpio_irqen_o[k]      = gctl[k].irqen;
        assign gpio_fsel_o[k*2 +: 2] = gctl[k].fsel;
    end

    logic [7:0] bank_rd;
    always_comb begin
        bank_rd = gpio_rd;
        for (int i = 0; i < NUM_DEV; i++) bank_rd = bank_rd | dev_rd[i];
    end

    always_comb begin
        rdata = 8'hFF;
        if (idx_rd) begin
            rdata = idx_q;
        end else if (data_rd) begin
            case (idx_q)
                IX_DEVNUM: rdata = ldn_q;
                IX_ID:     rdata = CHIP_ID;
                IX_REV:    rdata = CHIP_REV;
                default:   rdata = bank_rd;
            endcase
        end
    end

    assign cfg_mode_o = cfg_mode;

endmodule

// File: rtl/cfgspace_ctrl_chk.sv
module cfgspace_ctrl_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [15:0] IDX_PORT = 16'h03F0,
    parameter int unsigned NUM_DEV  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     addr,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic                  cfg_mode_o,
    input logic [NUM_DEV-1:0]    dev_active_o,
    input logic [NUM_DEV*16-1:0] pri_base_o,
    input logic [7:0]            idx_q
);
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(IDX_PORT);
    localparam logic [ADDR_W-1:0] DA = ADDR_W'(IDX_PORT + 16'd1);

    // R2
    enter_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode_o && wr_en && addr == IA && wdata == 8'h55) |=> cfg_mode_o);

    // R2
    leave_key_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode_o && wr_en && addr == IA && wdata == 8'hAA) |=> !cfg_mode_o);

    // R3
    run_data_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode_o && wr_en && addr == DA) |=> ($stable(dev_active_o) && $stable(pri_base_o)));

    // R3
    run_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode_o && rd_en && (addr == DA || addr == IA)) |-> rdata == 8'hFF);

    // R3
    run_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode_o) |=> $stable(idx_q));

    // R6
    chip_id_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode_o && rd_en && addr == DA && idx_q == 8'h20) |-> rdata == 8'h30);

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable(dev_active_o));

endmodule

bind cfgspace_ctrl cfgspace_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .NUM_DEV  (NUM_DEV)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .cfg_mode_o   (cfg_mode_o),
    .dev_active_o (dev_active_o),
    .pri_base_o   (pri_base_o),
    .idx_q        (idx_q)
);

// File: tb/cfgspace_ctrl_tb_top.sv
module cfgspace_ctrl_tb_top;
    localparam logic [15:0] IA = 16'h03F0;
    localparam logic [15:0] DA = 16'h03F1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  addr = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         cfg_mode_o;
    logic [7:0]   dev_active_o;
    logic [127:0] pri_base_o, sec_base_o;
    logic [63:0]  pri_irq_o, sec_irq_o;
    logic [7:0]   gpio_dir_o, gpio_inv_o, gpio_irqen_o;
    logic [15:0]  gpio_fsel_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        m_act [8];
    logic [15:0] m_pb [8];
    logic [15:0] m_sb [8];
    logic [7:0]  m_pi [8];
    logic [7:0]  m_si [8];
    logic [4:0]  m_gp [8];
    logic [7:0]  m_ldn;

    cfgspace_ctrl dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cfg_mode_o(cfg_mode_o),
        .dev_active_o(dev_active_o), .pri_base_o(pri_base_o),
        .sec_base_o(sec_base_o), .pri_irq_o(pri_irq_o), .sec_irq_o(sec_irq_o),
        .gpio_dir_o(gpio_dir_o), .gpio_inv_o(gpio_inv_o),
        .gpio_irqen_o(gpio_irqen_o), .gpio_fsel_o(gpio_fsel_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] ix, input logic [7:0] v);
        bus_wr(IA, ix);
        bus_wr(DA, v);
    endtask

    task automatic cfg_rd(input logic [7:0] ix, output logic [7:0] v);
        bus_wr(IA, ix);
        bus_rd(DA, v);
    endtask

    function automatic bit is_impl(input logic [7:0] ldn, input logic [7:0] ix);
        if (ix == 8'h07 || ix == 8'h20 || ix == 8'h21) return 1'b1;
        if (ldn < 8 && (ix == 8'h30 || ix == 8'h60 || ix == 8'h61 || ix == 8'h62 ||
                        ix == 8'h63 || ix == 8'h70 || ix == 8'h72)) return 1'b1;
        if (ldn == 8 && ix >= 8'hC0 && ix <= 8'hC7) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] ix);
        if (ix == 8'h07) return m_ldn;
        if (ix == 8'h20) return 8'h30;
        if (ix == 8'h21) return 8'h01;
        if (m_ldn < 8) begin
            case (ix)
                8'h30: return {7'd0, m_act[m_ldn[2:0]]};
                8'h60: return m_pb[m_ldn[2:0]][15:8];
                8'h61: return m_pb[m_ldn[2:0]][7:0];
                8'h62: return m_sb[m_ldn[2:0]][15:8];
                8'h63: return m_sb[m_ldn[2:0]][7:0];
                8'h70: return m_pi[m_ldn[2:0]];
                8'h72: return m_si[m_ldn[2:0]];
                default: return 8'h00;
            endcase
        end
        if (m_ldn == 8 && ix >= 8'hC0 && ix <= 8'hC7) return {3'b000, m_gp[ix[2:0]]};
        return 8'h00;
    endfunction

    task automatic check_outputs(input string req);
        for (int d = 0; d < 8; d++) begin
            chk(req, dev_active_o[d], m_act[d]);
            chk(req, pri_base_o[d*16 +: 16], m_pb[d]);
            chk(req, sec_base_o[d*16 +: 16], m_sb[d]);
            chk(req, pri_irq_o[d*8 +: 8], m_pi[d]);
            chk(req, sec_irq_o[d*8 +: 8], m_si[d]);
        end
        for (int k = 0; k < 8; k++) begin
            chk(req, gpio_dir_o[k], m_gp[k][0]);
            chk(req, gpio_inv_o[k], m_gp[k][1]);
            chk(req, gpio_irqen_o[k], m_gp[k][2]);
            chk(req, gpio_fsel_o[k*2 +: 2], m_gp[k][4:3]);
        end
    endtask

    task automatic sweep_read(input string req);
        logic [7:0] v;
        for (int ix = 0; ix < 256; ix++) begin
            if (ix != 8'hAA) begin
                cfg_rd(8'(ix), v);
                chk(req, {24'd0, v}, {24'd0, exp_rd(8'(ix))});
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int d = 0; d < 8; d++) begin
            m_act[d] = 0; m_pb[d] = 0; m_sb[d] = 0; m_pi[d] = 0; m_si[d] = 0; m_gp[d] = 0;
        end
        m_ldn = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 cfg_mode", cfg_mode_o, 0);
        check_outputs("R1");

        // R3 locked: reads return FF, writes ignored
        bus_rd(DA, v); chk("R3 data rd run", v, 8'hFF);
        bus_rd(IA, v); chk("R3 idx rd run", v, 8'hFF);
        bus_wr(DA, 8'h12);
        bus_wr(IA, 8'hAA);
        bus_wr(IA, 8'h30);
        #1 chk("R3 still run", cfg_mode_o, 0);
        check_outputs("R3");

        // R2 unlock, index unchanged by run writes or key
        bus_wr(IA, 8'h55);
        #1 chk("R2 enter", cfg_mode_o, 1);
        bus_rd(IA, v); chk("R3 idx untouched", v, 8'h00);

        // R4 index readback
        bus_wr(IA, 8'h5C);
        bus_rd(IA, v); chk("R4 idx rb", v, 8'h5C);
        bus_rd(16'h0100, v); chk("R4 other addr", v, 8'hFF);
        @(negedge clk); addr = DA; rd_en = 1'b0;
        #1 chk("R4 rd_en low", rdata, 8'hFF);

        // R6 id/rev read-only
        cfg_rd(8'h20, v); chk("R6 id", v, 8'h30);
        cfg_rd(8'h21, v); chk("R6 rev", v, 8'h01);
        cfg_wr(8'h20, 8'h99); cfg_wr(8'h21, 8'h77);
        cfg_rd(8'h20, v); chk("R6 id after wr", v, 8'h30);
        cfg_rd(8'h21, v); chk("R6 rev after wr", v, 8'h01);

        // R5 R7 R8 R9 program every device bank
        for (int d = 0; d < 8; d++) begin
            cfg_wr(8'h07, 8'(d)); m_ldn = 8'(d);
            cfg_rd(8'h07, v); chk("R5 devnum rb", v, 8'(d));
            cfg_wr(8'h30, (d % 2 == 0) ? 8'h01 : 8'hFE); m_act[d] = (d % 2 == 0);
            m_pb[d] = {8'(8'h10 + d), 8'(8'hF0 - d)};
            m_sb[d] = {8'(8'h20 + d), 8'(8'h06 + d)};
            m_pi[d] = 8'(8'h30 + d);
            m_si[d] = 8'(8'h40 + d);
            cfg_wr(8'h60, m_pb[d][15:8]); cfg_wr(8'h61, m_pb[d][7:0]);
            cfg_wr(8'h62, m_sb[d][15:8]); cfg_wr(8'h63, m_sb[d][7:0]);
            cfg_wr(8'h70, m_pi[d]);       cfg_wr(8'h72, m_si[d]);
        end
        @(negedge clk);
        check_outputs("R7 R8 R9 banks");

        // R10 GPIO bytes in bank 8
        cfg_wr(8'h07, 8'd8); m_ldn = 8'd8;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] gv;
            gv = 8'(8'hA0 ^ (k * 5));
            cfg_wr(8'(8'hC0 + k), gv);
            m_gp[k] = gv[4:0];
            cfg_rd(8'(8'hC0 + k), v); chk("R10 gpio rb", v, {3'b000, gv[4:0]});
        end
        @(negedge clk);
        check_outputs("R10 fields");

        // R11 R5 full read sweeps
        foreach (m_act[i]) begin end
        cfg_wr(8'h07, 8'd3); m_ldn = 8'd3; sweep_read("R11 sweep dev3");
        cfg_wr(8'h07, 8'd8); m_ldn = 8'd8; sweep_read("R11 sweep aux");
        cfg_wr(8'h07, 8'd9); m_ldn = 8'd9; sweep_read("R11 sweep ldn9");
        cfg_wr(8'h07, 8'hFF); m_ldn = 8'hFF; sweep_read("R11 sweep ldnFF");

        // R11 write sweeps to unimplemented indexes
        for (int s = 0; s < 3; s++) begin
            logic [7:0] ln;
            ln = (s == 0) ? 8'd3 : (s == 1) ? 8'd8 : 8'd9;
            cfg_wr(8'h07, ln); m_ldn = ln;
            for (int ix = 0; ix < 256; ix++) begin
                if (ix != 8'hAA && !is_impl(ln, 8'(ix))) cfg_wr(8'(ix), 8'hFF);
            end
            @(negedge clk);
            check_outputs("R11 discard");
            sweep_read("R11 reread");
        end

        // R2 exit; R3 data write while locked with armed index
        cfg_wr(8'h07, 8'd2); m_ldn = 8'd2;
        bus_wr(IA, 8'h30);
        bus_wr(IA, 8'hAA);
        #1 chk("R2 leave", cfg_mode_o, 0);
        bus_wr(DA, 8'h00);
        bus_rd(DA, v); chk("R3 data rd locked", v, 8'hFF);
        @(negedge clk);
        chk("R3 dev2 still active", dev_active_o[2], 1);
        check_outputs("R3 locked write");
        bus_wr(IA, 8'h55);
        #1 chk("R2 re-enter", cfg_mode_o, 1);
        bus_rd(IA, v); chk("R4 idx kept", v, 8'h30);
        bus_rd(DA, v); chk("R7 act dev2", v, 8'h01);

        // R2 0x55 in config loads the index
        bus_wr(IA, 8'h55);
        #1 chk("R2 stay cfg", cfg_mode_o, 1);
        bus_rd(IA, v); chk("R4 idx 55", v, 8'h55);

        // R1 reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int d = 0; d < 8; d++) begin
            m_act[d] = 0; m_pb[d] = 0; m_sb[d] = 0; m_pi[d] = 0; m_si[d] = 0; m_gp[d] = 0;
        end
        #1 chk("R1 cfg after rst", cfg_mode_o, 0);
        check_outputs("R1 after rst");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule